// File: doc/BRIEF.md
# Binary Pixel Cluster Encoder

This block sits after the discriminators of a rolling-shutter binary pixel array. At each readout step the array presents two rows of one-bit hit flags together. The block scans the first row and then the second. It folds every run of fired pixels into cluster words, and each word names the pixel row, the first fired column and a four-column hit mask. Rows with no hits produce nothing, so the output rate follows the hit density and not the array size.

The columns are cut into fixed groups. A group may emit only a bounded number of cluster words per row; any hits beyond that bound are discarded and recorded in a per-frame overflow flag. A header word carrying a running frame number opens each frame. A trailer word carrying the overflow flag and the number of cluster words closes it.

Words leave through a valid/ready stream behind a small FIFO, so downstream stalls cost no data. The encoder accepts a new row pair or frame marker only when it is idle and the FIFO has room.

Top module: `zsEncoder`

## Requirements
- R1: After reset `outValid` is low and `inReady` is high.
- R2: An accepted `frameStart` queues a header word: bits [20:19] = 01, bits [15:0] = frame number (0 for the first frame after reset, then +1 per header), and bits [18:16] = 0.
- R3: A cluster word has bits [20:19] = 10, bits [18:10] = row address, bits [9:4] = start column and bits [3:0] = mask. The row address is {`rowIdx`, 0} for `hitsA` and {`rowIdx`, 1} for `hitsB`. Mask bit k is the hit flag at column start+k, so bit 0 is always 1.
- R4: A window covers at most four columns and never crosses a group boundary, where a group is 16 aligned columns. The next word of the row starts at the lowest fired column after the window.
- R5: A row with no fired pixels produces no cluster word.
- R6: Within a pair, the words for `hitsA` leave before those for `hitsB`, and within a row they leave in ascending start column.
- R7: A group emits at most 2 cluster words per row. Hits that would need more words are dropped, and the frame's overflow flag is set.
- R8: An accepted `frameEnd` queues a trailer word: bits [20:19] = 11, bit 18 = overflow flag, bits [17:16] = 0, and bits [15:0] = number of cluster words since the last header.
- R9: While `outReady` is low, a presented word stays valid and unchanged. No word is lost, duplicated or reordered under back-pressure.
- R10: Once a row pair is accepted, `inReady` is low on the next cycle. Only one of `frameStart`, `frameEnd` and `rowValid` is raised at a time, and only while `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Open a frame (queue header) |
| frameEnd | input | 1 | Close a frame (queue trailer) |
| rowValid | input | 1 | Row pair present on hitsA/hitsB |
| rowIdx | input | 8 | Row pair index |
| hitsA | input | 64 | Hit flags, first row of the pair |
| hitsB | input | 64 | Hit flags, second row of the pair |
| inReady | output | 1 | Encoder can accept a marker or row pair |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Downstream accepts the word |
| outWord | output | 21 | Header, cluster or trailer word |

## Verification
Empty frames and empty rows show that suppression leaves only the header and trailer. Single hits and runs of six separate the mask coding from the window step. Runs that straddle column 16 show the cut at the group boundary. Three isolated hits in one group and fully fired rows exercise the per-group limit and the trailer's overflow flag. Sparse random pairs under random back-pressure check ordering, counts and frame numbering against a reference model. A second frame with no overflow shows that the flag clears.

// File: rtl/zsPkg.sv
package zsPkg;
  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,
    TAG_HDR  = 2'b01,
    TAG_CLU  = 2'b10,
    TAG_TRL  = 2'b11
  } zsTag_e;

  typedef struct packed {
    logic loadRows;
    logic nextRow;
    logic emitHdr;
    logic emitClu;
    logic emitTrl;
    logic dropGrp;
  } zsStrobe_t;
endpackage

// File: rtl/zsFifo.sv
module zsFifo #(
  parameter int WIDTH = 21,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      fill;

  assign notEmpty = (fill != '0);
  assign full     = (fill == (AW+1)'(DEPTH));
  assign headData = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/zsCtrl.sv
module zsCtrl
  import zsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      frameEnd,
  input  logic      rowValid,
  input  logic      fifoFull,
  input  logic      curEmpty,
  input  logic      groupFull,
  input  logic      rowSel,
  output logic      inReady,
  output zsStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
  state_e state, nextState;

  always_comb begin
    strobe    = '0;
    inReady   = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        inReady = !fifoFull;
        if (inReady) begin
          if (frameStart)    strobe.emitHdr = 1'b1;
          else if (frameEnd) strobe.emitTrl = 1'b1;
          else if (rowValid) begin
            strobe.loadRows = 1'b1;
            nextState       = ST_SCAN;
          end
        end
      end
      default: begin
        if (curEmpty) begin
          if (rowSel) nextState = ST_IDLE;
          else        strobe.nextRow = 1'b1;
        end else if (groupFull) begin
          strobe.dropGrp = 1'b1;
        end else if (!fifoFull) begin
          strobe.emitClu = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/zsData.sv
module zsData
  import zsPkg::*;
#(
  parameter int COLS        = 64,
  parameter int GROUP_W     = 16,
  parameter int MAX_PER_GRP = 2,
  parameter int PAIR_W      = 8,
  parameter int FCNT_W      = 16,
  parameter int WW          = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  zsStrobe_t         strobe,
  input  logic [PAIR_W-1:0] rowIdx,
  input  logic [COLS-1:0]   hitsA,
  input  logic [COLS-1:0]   hitsB,
  output logic              curEmpty,
  output logic              groupFull,
  output logic              rowSel,
  output logic              push,
  output logic [WW-1:0]     pushWord
);
  localparam int CW    = $clog2(COLS);
  localparam int NG    = COLS / GROUP_W;
  localparam int GWL   = $clog2(GROUP_W);
  localparam int GBW   = (NG > 1) ? $clog2(NG) : 1;
  localparam int CNTW  = $clog2(MAX_PER_GRP + 1);
  localparam int RW    = PAIR_W + 1;
  localparam int PAYW  = RW + CW + 4;

  logic [COLS-1:0]   curRow, holdB, winVec, grpVec;
  logic [PAIR_W-1:0] pairIdx;
  logic [CW-1:0]     firstCol;
  logic [GBW-1:0]    grp, lastGrp;
  logic [CNTW-1:0]   cnt;
  logic              cntValid, sameGrp, ovf;
  logic [3:0]        mask;
  logic [FCNT_W-1:0] frameCnt, wordCnt;

  assign curEmpty = (curRow == '0);

  // lowest fired column of the working row
  always_comb begin
    firstCol = '0;
    for (int i = COLS - 1; i >= 0; i--)
      if (curRow[i]) firstCol = CW'(i);
  end

  assign grp       = GBW'(firstCol >> GWL);
  assign sameGrp   = cntValid && (grp == lastGrp);
  assign groupFull = sameGrp && (cnt == CNTW'(MAX_PER_GRP));

  // window and group selection vectors
  always_comb begin
    for (int i = 0; i < COLS; i++) begin
      grpVec[i] = ((i >> GWL) == int'(grp));
      winVec[i] = grpVec[i] && (i >= int'(firstCol)) && (i < int'(firstCol) + 4);
    end
    for (int k = 0; k < 4; k++) begin
      mask[k] = 1'b0;
      if (int'(firstCol) + k < COLS)
        mask[k] = winVec[int'(firstCol) + k] && curRow[int'(firstCol) + k];
    end
  end

  assign push = strobe.emitHdr || strobe.emitClu || strobe.emitTrl;

  always_comb begin
    if (strobe.emitHdr)
      pushWord = {TAG_HDR, {(PAYW-FCNT_W){1'b0}}, frameCnt};
    else if (strobe.emitTrl)
      pushWord = {TAG_TRL, ovf, {(PAYW-1-FCNT_W){1'b0}}, wordCnt};
    else
      pushWord = {TAG_CLU, pairIdx, rowSel, firstCol, mask};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      holdB    <= '0;
      pairIdx  <= '0;
      rowSel   <= 1'b0;
      cnt      <= '0;
      cntValid <= 1'b0;
      lastGrp  <= '0;
      ovf      <= 1'b0;
      frameCnt <= '0;
      wordCnt  <= '0;
    end else begin
      if (strobe.loadRows) begin
        curRow   <= hitsA;
        holdB    <= hitsB;
        pairIdx  <= rowIdx;
        rowSel   <= 1'b0;
        cnt      <= '0;
        cntValid <= 1'b0;
      end
      if (strobe.nextRow) begin
        curRow   <= holdB;
        rowSel   <= 1'b1;
        cnt      <= '0;
        cntValid <= 1'b0;
      end
      if (strobe.emitClu) begin
        curRow   <= curRow & ~winVec;
        cnt      <= sameGrp ? cnt + 1'b1 : CNTW'(1);
        lastGrp  <= grp;
        cntValid <= 1'b1;
        wordCnt  <= wordCnt + 1'b1;
      end
      if (strobe.dropGrp) begin
        curRow <= curRow & ~grpVec;
        ovf    <= 1'b1;
      end
      if (strobe.emitHdr) begin
        frameCnt <= frameCnt + 1'b1;
        wordCnt  <= '0;
        ovf      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zsEncoder.sv
module zsEncoder
  import zsPkg::*;
#(
  parameter int COLS        = 64,
  parameter int GROUP_W     = 16,
  parameter int MAX_PER_GRP = 2,
  parameter int PAIR_W      = 8,
  parameter int FCNT_W      = 16,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              rowValid,
  input  logic [PAIR_W-1:0] rowIdx,
  input  logic [COLS-1:0]   hitsA,
  input  logic [COLS-1:0]   hitsB,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [2+PAIR_W+1+$clog2(COLS)+4-1:0] outWord
);
  localparam int WW = 2 + PAIR_W + 1 + $clog2(COLS) + 4;

  zsStrobe_t     strobe;
  logic          fifoFull, curEmpty, groupFull, rowSel, push;
  logic [WW-1:0] pushWord;

  zsCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .rowValid(rowValid), .fifoFull(fifoFull), .curEmpty(curEmpty),
    .groupFull(groupFull), .rowSel(rowSel), .inReady(inReady), .strobe(strobe)
  );

  zsData #(
    .COLS(COLS), .GROUP_W(GROUP_W), .MAX_PER_GRP(MAX_PER_GRP),
    .PAIR_W(PAIR_W), .FCNT_W(FCNT_W), .WW(WW)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowIdx(rowIdx),
    .hitsA(hitsA), .hitsB(hitsB), .curEmpty(curEmpty),
    .groupFull(groupFull), .rowSel(rowSel), .push(push), .pushWord(pushWord)
  );

  zsFifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .push(push), .pushData(pushWord),
    .pop(outValid && outReady), .headData(outWord),
    .notEmpty(outValid), .full(fifoFull)
  );
endmodule

// File: rtl/zsEncoderChk.sv
module zsEncoderChk #(
  parameter int WW = 21
) (
  input logic          clk,
  input logic          rstN,
  input logic          inReady,
  input logic          rowValid,
  input logic          outValid,
  input logic          outReady,
  input logic [WW-1:0] outWord
);
  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outWord));

  // R10
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady && rowValid |=> !inReady);

  // R8
  tag_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outWord[WW-1 -: 2] != 2'b00);

  // R3
  mask_anchor_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outWord[WW-1 -: 2] == 2'b10 |-> outWord[0]);
endmodule

bind zsEncoder zsEncoderChk #(.WW(WW)) chk_i (
  .clk(clk), .rstN(rstN), .inReady(inReady), .rowValid(rowValid),
  .outValid(outValid), .outReady(outReady), .outWord(outWord)
);

// File: tb/zsEncoder_tb_top.sv
module zsEncoder_tb_top;
  localparam int COLS = 64, GW = 16, MAXW = 2, PW = 8, WW = 21;

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 1'b0, frameEnd = 1'b0, rowValid = 1'b0, outReady = 1'b1;
  logic [PW-1:0] rowIdx = '0;
  logic [COLS-1:0] hitsA = '0, hitsB = '0;
  logic inReady, outValid;
  logic [WW-1:0] outWord;

  int checks = 0, errors = 0;
  logic [WW-1:0] expQ[$];
  int frameNo = 0, expWords = 0;
  bit expOvf = 0, bpOn = 0, done = 0;

  always #10 clk = ~clk;

  zsEncoder dut_i (.*);

  always @(posedge clk) outReady <= bpOn ? $urandom_range(0, 2) != 0 : 1'b1;

  // monitor: compare each accepted word against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected word actual=%h expected=none", outWord);
      end else begin
        logic [WW-1:0] e;
        e = expQ.pop_front();
        if (e !== outWord) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h",
            e[20:19] == 2'b01 ? "R2" : e[20:19] == 2'b11 ? "R8" : "R3 R4 R6 R7 R9",
            outWord, e);
        end
      end
    end
  end

  task automatic waitReady();
    @(negedge clk);
    while (!inReady) @(negedge clk);
  endtask

  task automatic startFrame();
    expQ.push_back({2'b01, 3'b000, 16'(frameNo)});
    frameNo++; expWords = 0; expOvf = 0;
    waitReady(); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
  endtask

  task automatic endFrame();
    expQ.push_back({2'b11, expOvf, 2'b00, 16'(expWords)});
    waitReady(); frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0;
  endtask

  // reference model of the requirements R3 R4 R5 R6 R7
  task automatic modelRow(input logic [PW-1:0] idx, input bit sel, input logic [COLS-1:0] r);
    int cnt[COLS/GW];
    int c = 0;
    foreach (cnt[g]) cnt[g] = 0;
    while (c < COLS) begin
      if (r[c]) begin
        int g = c / GW;
        int gEnd = (g + 1) * GW;
        if (cnt[g] < MAXW) begin
          logic [3:0] m = '0;
          for (int k = 0; k < 4; k++)
            if (c + k < gEnd) m[k] = r[c + k];
          expQ.push_back({2'b10, idx, sel, 6'(c), m});
          cnt[g]++; expWords++;
          c = (c + 4 < gEnd) ? c + 4 : gEnd;
        end else begin
          expOvf = 1;
          c = gEnd;
        end
      end else c++;
    end
  endtask

  task automatic sendPair(input logic [PW-1:0] idx, input logic [COLS-1:0] a, input logic [COLS-1:0] b);
    modelRow(idx, 1'b0, a);
    modelRow(idx, 1'b1, b);
    waitReady();
    rowIdx = idx; hitsA = a; hitsB = b; rowValid = 1'b1;
    @(negedge clk); rowValid = 1'b0;
    checks++;
    if (inReady !== 1'b0) begin
      errors++;
      $display("FAIL R10 inReady after load actual=%b expected=0", inReady);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b expected=01", outValid, inReady);
    end
    // R2 R8 R5: empty frame, then empty rows
    startFrame(); endFrame();
    startFrame(); sendPair(8'd0, '0, '0); sendPair(8'd1, '0, '0); endFrame();
    // R3 R6: single hits in both rows; R4: run of six and boundary straddle
    startFrame();
    sendPair(8'd5, 64'h1 << 9, 64'h1 << 63);
    sendPair(8'd6, 64'h3F << 20, 64'hF << 14);
    sendPair(8'd200, 64'h8 | (64'h1 << 40), 64'h5 << 46);
    endFrame();
    // R7: three isolated hits in one group, and full rows
    startFrame();
    sendPair(8'd7, (64'h1 << 1) | (64'h1 << 6) | (64'h1 << 11), '0);
    sendPair(8'd8, '1, '1);
    endFrame();
    // R7 R8: overflow flag clears in next frame
    startFrame(); sendPair(8'd9, 64'h1 << 33, '0); endFrame();
    // R9: random sparse rows under back-pressure
    bpOn = 1;
    for (int f = 0; f < 4; f++) begin
      startFrame();
      for (int p = 0; p < 12; p++) begin
        logic [COLS-1:0] a, b;
        a = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        b = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        sendPair(8'(p * 3 + f), a, b);
      end
      endFrame();
    end
    for (int w = 0; w < 2000 && expQ.size() != 0; w++) @(negedge clk);
    repeat (5) @(negedge clk);
    checks++;
    if (expQ.size() != 0 || outValid) begin
      errors++;
      $display("FAIL R9 leftover actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule